// File: doc/BRIEF.md
# DMA Channel Termination Sequencer

This block is the control state machine of a single DMA channel. Software starts the channel in one of two modes. In direct mode the channel runs one transfer. In linked-list mode it runs a chain of descriptors: it fetches a descriptor, runs its transfer, and then moves on to the next one. The descriptor fetch engine and the data transfer engine are outside the block. They are reached through simple request/done/error handshakes. A request stays high until the engine answers, and the engine answers with a one-cycle done or error strobe.

The sequencer decides how the channel ends. A run can end in four ways: it finishes normally, software pauses it, software aborts it, or an engine reports an error.
- A pause waits for the next descriptor boundary. It leaves the chain resumable from the saved next-link pointer.
- An abort cuts the channel off in the cycle it is seen, and the chain cannot be resumed.
- An error also stops the channel for good.

Every terminal status can raise a one-cycle interrupt when interrupts are enabled.

Each fetched descriptor returns a next-link pointer. Its bit 0 is the end-of-chain flag: a value of 1 marks the descriptor just fetched as the last one. The pointer is kept as the channel's saved next-link value once that descriptor's transfer has ended.

Top module: `dma_term_seq`

## Requirements
- R1: After reset, status reads 0 (idle), fetch_req, xfer_req and irq are low. Status codes are 0 idle, 1 busy, 2 done, 3 paused, 4 aborted, 5 error.
- R2: A start with link_mode=0 raises xfer_req in the next cycle, never raises fetch_req, and a non-error xfer_done ends the run with status 2.
- R3: A start with link_mode=1 loads first_link into next_link and fetches from it. Each fetch_done stores fetch_next, and the transfer is then requested. When the transfer ends, next_link takes the stored pointer. If bit 0 of that pointer is 0, the next fetch starts at that pointer with bit 0 cleared. If bit 0 is 1, the run ends with status 2. fetch_req and xfer_req are never high together.
- R4: irq is high for exactly the one cycle in which a terminal status (2 to 5) first appears, and only if irq_en was high when that status was written.
- R5: A pause_req seen while busy is held until a linked-mode transfer ends. If that descriptor was not the last, status becomes 3 and no further fetch is issued.
- R6: A held pause at the end of the last descriptor, or during a direct-mode transfer, ends the run with status 2.
- R7: A start with link_mode=1 while status is 3 resumes the chain: the first fetch uses the saved next_link, and first_link is ignored.
- R8: An abort_req while busy ends the run at the next clock edge with status 4, drops both requests, and leaves nothing to resume. The exception is an abort in the same cycle as the last transfer's done, which ends with status 2.
- R9: A fetch_err during a fetch or an xfer_err during a transfer ends the run with status 5. This has priority over an abort in the same cycle. A later start begins a fresh run at first_link.
- R10: When a held pause and an abort_req meet at a non-final descriptor boundary, the abort wins and status becomes 4.
- R11: A start while busy has no effect on the requests or on next_link. pause_req and abort_req while not busy are discarded and do not affect the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or resume strobe |
| link_mode | input | 1 | 1 = linked-list mode, 0 = direct mode (sampled with start) |
| first_link | input | AW | Address of the first descriptor for a fresh linked run |
| pause_req | input | 1 | Pause request strobe |
| abort_req | input | 1 | Abort request strobe |
| irq_en | input | 1 | Interrupt enable |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | AW | Descriptor address (flag bit cleared) |
| fetch_done | input | 1 | Fetch finished, fetch_next valid |
| fetch_err | input | 1 | Fetch failed |
| fetch_next | input | AW | Next-link pointer of the fetched descriptor, bit 0 = end of chain |
| xfer_req | output | 1 | Data transfer request |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer failed |
| next_link | output | AW | Saved next-link pointer |
| status | output | 3 | Channel status code |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Several ways of ending a run can fall on the same clock edge. An abort can meet the last transfer's done, a held pause can meet an abort at a descriptor boundary, and an engine error can meet an abort. The bench provokes each collision on purpose by driving both strobes in the same cycle while the request is open. It judges the result by the status and irq seen one cycle later, against the precedence set by R8, R9 and R10. Random chains then mix pauses, resumes, aborts and fetch errors at random descriptor positions, and a bench function predicts each ending.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BUSY    = 3'd1,
    ST_DONE    = 3'd2,
    ST_PAUSED  = 3'd3,
    ST_ABORTED = 3'd4,
    ST_ERROR   = 3'd5
  } chan_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_XFER  = 2'd2
  } phase_e;

endpackage

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         link_mode,
  input  logic         pause_req,
  input  logic         abort_req,
  input  logic         fetch_done,
  input  logic         fetch_err,
  input  logic         xfer_done,
  input  logic         xfer_err,
  input  logic         last_flag,
  input  logic         resumable,
  output phase_e       phase,
  output logic         begin_run,
  output logic         load_first,
  output logic         capture_desc,
  output logic         commit_link,
  output logic         term_valid,
  output chan_status_e term_code
);

  phase_e phase_q, phase_nx;
  logic   mode_q, mode_nx;
  logic   pause_q, pause_nx;

  logic busy, go, seg_end, final_seg, err_hit, pause_hit;

  always_comb begin
    busy      = (phase_q != PH_IDLE);
    go        = start && !busy;
    seg_end   = (phase_q == PH_XFER) && xfer_done;
    final_seg = seg_end && (!mode_q || last_flag);
    err_hit   = ((phase_q == PH_FETCH) && fetch_err) ||
                ((phase_q == PH_XFER)  && xfer_err);
    pause_hit = pause_q || pause_req;
  end

  // Next-state logic: error > final completion > abort > boundary handling
  always_comb begin
    phase_nx   = phase_q;
    term_valid = 1'b0;
    term_code  = ST_IDLE;
    unique case (phase_q)
      PH_IDLE: begin
        if (go) phase_nx = link_mode ? PH_FETCH : PH_XFER;
      end
      PH_FETCH, PH_XFER: begin
        if (err_hit) begin
          term_valid = 1'b1;
          term_code  = ST_ERROR;
          phase_nx   = PH_IDLE;
        end else if (final_seg) begin
          term_valid = 1'b1;
          term_code  = ST_DONE;
          phase_nx   = PH_IDLE;
        end else if (abort_req) begin
          term_valid = 1'b1;
          term_code  = ST_ABORTED;
          phase_nx   = PH_IDLE;
        end else if ((phase_q == PH_FETCH) && fetch_done) begin
          phase_nx = PH_XFER;
        end else if (seg_end) begin
          if (pause_hit) begin
            term_valid = 1'b1;
            term_code  = ST_PAUSED;
            phase_nx   = PH_IDLE;
          end else begin
            phase_nx = PH_FETCH;
          end
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    mode_nx  = go ? link_mode : mode_q;
    pause_nx = pause_q;
    if (phase_nx == PH_IDLE)   pause_nx = 1'b0;
    else if (busy && pause_req) pause_nx = 1'b1;
  end

  always_comb begin
    begin_run    = go;
    load_first   = go && link_mode && !resumable;
    capture_desc = (phase_q == PH_FETCH) && fetch_done && !fetch_err;
    commit_link  = seg_end && mode_q && !xfer_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      pause_q <= pause_nx;
      if (go) mode_q <= mode_nx;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/dma_term_link.sv
module dma_term_link #(
  parameter int AW       = 16,
  parameter int LAST_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_first,
  input  logic [AW-1:0] first_link,
  input  logic          capture_desc,
  input  logic [AW-1:0] fetch_next,
  input  logic          commit_link,
  output logic [AW-1:0] next_link,
  output logic [AW-1:0] fetch_addr,
  output logic          last_flag
);

  localparam logic [AW-1:0] FLAG_MASK = {{(AW-1){1'b0}}, 1'b1} << LAST_BIT;

  logic [AW-1:0] link_q, link_nx;
  logic [AW-1:0] desc_q, desc_nx;
  logic          link_en;

  always_comb begin
    link_en = load_first || commit_link;
    link_nx = load_first ? first_link : desc_q;
    desc_nx = fetch_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      desc_q <= '0;
    end else begin
      if (link_en)      link_q <= link_nx;
      if (capture_desc) desc_q <= desc_nx;
    end
  end

  assign next_link  = link_q;
  assign fetch_addr = link_q & ~FLAG_MASK;
  assign last_flag  = desc_q[LAST_BIT];

endmodule

// File: rtl/dma_term_stat.sv
module dma_term_stat
  import dma_term_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         begin_run,
  input  logic         term_valid,
  input  chan_status_e term_code,
  input  logic         irq_en,
  output chan_status_e status,
  output logic         irq
);

  chan_status_e stat_q, stat_nx;
  logic         irq_q, irq_nx;
  logic         stat_en;

  always_comb begin
    stat_en = begin_run || term_valid;
    stat_nx = begin_run ? ST_BUSY : term_code;
    irq_nx  = term_valid && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_IDLE;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_nx;
      irq_q <= irq_nx;
    end
  end

  assign status = stat_q;
  assign irq    = irq_q;

endmodule

// File: rtl/dma_term_seq.sv
module dma_term_seq
  import dma_term_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LAST_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_mode,
  input  logic [AW-1:0] first_link,
  input  logic          pause_req,
  input  logic          abort_req,
  input  logic          irq_en,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_done,
  input  logic          fetch_err,
  input  logic [AW-1:0] fetch_next,
  output logic          xfer_req,
  input  logic          xfer_done,
  input  logic          xfer_err,
  output logic [AW-1:0] next_link,
  output logic [2:0]    status,
  output logic          irq
);

  phase_e       phase;
  chan_status_e stat;
  chan_status_e term_code;
  logic begin_run, load_first, capture_desc, commit_link, term_valid;
  logic last_flag, resumable;

  assign resumable = (stat == ST_PAUSED);

  dma_term_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .link_mode    (link_mode),
    .pause_req    (pause_req),
    .abort_req    (abort_req),
    .fetch_done   (fetch_done),
    .fetch_err    (fetch_err),
    .xfer_done    (xfer_done),
    .xfer_err     (xfer_err),
    .last_flag    (last_flag),
    .resumable    (resumable),
    .phase        (phase),
    .begin_run    (begin_run),
    .load_first   (load_first),
    .capture_desc (capture_desc),
    .commit_link  (commit_link),
    .term_valid   (term_valid),
    .term_code    (term_code)
  );

  dma_term_link #(.AW(AW), .LAST_BIT(LAST_BIT)) u_link (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_first   (load_first),
    .first_link   (first_link),
    .capture_desc (capture_desc),
    .fetch_next   (fetch_next),
    .commit_link  (commit_link),
    .next_link    (next_link),
    .fetch_addr   (fetch_addr),
    .last_flag    (last_flag)
  );

  dma_term_stat u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .begin_run  (begin_run),
    .term_valid (term_valid),
    .term_code  (term_code),
    .irq_en     (irq_en),
    .status     (stat),
    .irq        (irq)
  );

  assign fetch_req = (phase == PH_FETCH);
  assign xfer_req  = (phase == PH_XFER);
  assign status    = stat;

endmodule

// File: rtl/dma_term_seq_chk.sv
module dma_term_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort_req,
  input logic          irq_en,
  input logic          fetch_req,
  input logic          fetch_err,
  input logic          xfer_req,
  input logic          xfer_done,
  input logic          xfer_err,
  input logic [AW-1:0] next_link,
  input logic [2:0]    status,
  input logic          irq
);

  AST_NOT_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1) |-> (!fetch_req && !xfer_req)); // R1

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && xfer_req)); // R3

  AST_IRQ_ON_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(irq_en) && ($past(status) == 3'd1) && (status >= 3'd2))); // R4

  AST_ABORT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'd1) && abort_req) |=> (status != 3'd1)); // R8

  AST_ERROR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'd1) && ((fetch_req && fetch_err) || (xfer_req && xfer_err)))
      |=> (status == 3'd5)); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'd1) && start && xfer_req && !xfer_done && !xfer_err && !abort_req)
      |=> (xfer_req && $stable(next_link))); // R11

endmodule

bind dma_term_seq dma_term_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .abort_req (abort_req),
  .irq_en    (irq_en),
  .fetch_req (fetch_req),
  .fetch_err (fetch_err),
  .xfer_req  (xfer_req),
  .xfer_done (xfer_done),
  .xfer_err  (xfer_err),
  .next_link (next_link),
  .status    (status),
  .irq       (irq)
);

// File: tb/dma_term_seq_bench.sv
module dma_term_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam logic [2:0] S_IDLE = 3'd0, S_BUSY = 3'd1, S_DONE = 3'd2,
                         S_PAUSED = 3'd3, S_ABORTED = 3'd4, S_ERROR = 3'd5;

  logic          clk, rst_n;
  logic          start, link_mode, pause_req, abort_req, irq_en;
  logic [AW-1:0] first_link, fetch_next;
  logic          fetch_done, fetch_err, xfer_done, xfer_err;
  logic          fetch_req, xfer_req, irq;
  logic [AW-1:0] fetch_addr, next_link;
  logic [2:0]    status;

  int n_chk, n_fail, cycles;
  bit saw_fetch;

  dma_term_seq #(.AW(AW), .LAST_BIT(0)) u_dma_term_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .link_mode(link_mode),
    .first_link(first_link), .pause_req(pause_req), .abort_req(abort_req),
    .irq_en(irq_en), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_done(fetch_done), .fetch_err(fetch_err), .fetch_next(fetch_next),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .next_link(next_link), .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (fetch_req) saw_fetch <= 1'b1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] dsc_addr(input int base, input int i);
    return AW'(base + i * 16);
  endfunction

  function automatic logic [AW-1:0] dsc_ptr(input int base, input int i, input int n);
    return dsc_addr(base, i + 1) | AW'(i == n - 1);
  endfunction

  function automatic logic exp_irq(input logic [2:0] st, input logic en);
    return en && (st >= S_DONE);
  endfunction

  task automatic go(input logic mode, input logic [AW-1:0] first);
    start = 1'b1; link_mode = mode; first_link = first;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_req(input bit want_fetch, input string req);
    int k;
    for (k = 0; k < 40; k++) begin
      if (want_fetch ? fetch_req : xfer_req) break;
      tick();
    end
    chk(k < 40, req, 32'(k), 32'd0);
  endtask

  task automatic serve_fetch(input logic [AW-1:0] exp_addr, input logic [AW-1:0] ptr,
                             input bit done, input bit err, input bit abort, input string req);
    wait_req(1'b1, req);
    chk(fetch_addr == exp_addr, req, 32'(fetch_addr), 32'(exp_addr));
    repeat ($urandom % 3) tick();
    fetch_next = ptr; fetch_done = done; fetch_err = err; abort_req = abort;
    tick();
    fetch_done = 1'b0; fetch_err = 1'b0; abort_req = 1'b0;
  endtask

  task automatic serve_xfer(input bit done, input bit err, input bit abort,
                            input bit pause_first, input string req);
    wait_req(1'b0, req);
    if (pause_first) begin
      pause_req = 1'b1; tick(); pause_req = 1'b0;
    end
    repeat ($urandom % 3) tick();
    xfer_done = done; xfer_err = err; abort_req = abort;
    tick();
    xfer_done = 1'b0; xfer_err = 1'b0; abort_req = 1'b0;
  endtask

  task automatic expect_end(input logic [2:0] st, input string req);
    chk(status == st, req, 32'(status), 32'(st));
    chk(irq == exp_irq(st, irq_en), {req, " irq"}, 32'(irq), 32'(exp_irq(st, irq_en)));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    n_chk = 0; n_fail = 0; cycles = 0; saw_fetch = 1'b0;
    start = 0; link_mode = 0; first_link = '0; pause_req = 0; abort_req = 0;
    irq_en = 0; fetch_done = 0; fetch_err = 0; fetch_next = '0; xfer_done = 0; xfer_err = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(status == S_IDLE, "R1 status", 32'(status), 32'(S_IDLE));
    chk(!fetch_req && !xfer_req, "R1 requests", {30'd0, fetch_req, xfer_req}, 32'd0);
    chk(!irq, "R1 irq", 32'(irq), 32'd0);

    // R2 direct mode, interrupt enabled (R4)
    irq_en = 1'b1; saw_fetch = 1'b0;
    go(1'b0, 16'h0100);
    chk(xfer_req, "R2 xfer_req after start", 32'(xfer_req), 32'd1);
    serve_xfer(1, 0, 0, 0, "R2 transfer");
    expect_end(S_DONE, "R2 direct done R4");
    tick();
    chk(!irq, "R4 irq single cycle", 32'(irq), 32'd0);
    chk(!saw_fetch, "R2 no fetch in direct mode", 32'(saw_fetch), 32'd0);

    // R3 three-descriptor chain, interrupt disabled (R4)
    irq_en = 1'b0;
    go(1'b1, dsc_addr(16'h2000, 0));
    for (int i = 0; i < 3; i++) begin
      serve_fetch(dsc_addr(16'h2000, i), dsc_ptr(16'h2000, i, 3), 1, 0, 0, "R3 fetch address");
      serve_xfer(1, 0, 0, 0, "R3 transfer");
      if (i < 2) chk(status == S_BUSY, "R3 busy mid chain", 32'(status), 32'(S_BUSY));
    end
    expect_end(S_DONE, "R3 chain done R4 masked");
    chk(next_link == dsc_ptr(16'h2000, 2, 3), "R3 next_link saved", 32'(next_link), 32'(dsc_ptr(16'h2000, 2, 3)));

    // R6 pause during last descriptor, and during direct mode
    irq_en = 1'b1;
    go(1'b1, dsc_addr(16'h3000, 0));
    serve_fetch(dsc_addr(16'h3000, 0), dsc_ptr(16'h3000, 0, 1), 1, 0, 0, "R6 fetch");
    serve_xfer(1, 0, 0, 1, "R6 transfer");
    expect_end(S_DONE, "R6 pause on last gives done");
    go(1'b0, 16'h0);
    serve_xfer(1, 0, 0, 1, "R6 direct transfer");
    expect_end(S_DONE, "R6 pause in direct gives done");

    // R5 + R7 pause at boundary, then resume ignoring first_link
    go(1'b1, dsc_addr(16'h3400, 0));
    serve_fetch(dsc_addr(16'h3400, 0), dsc_ptr(16'h3400, 0, 2), 1, 0, 0, "R5 fetch");
    serve_xfer(1, 0, 0, 1, "R5 transfer");
    expect_end(S_PAUSED, "R5 paused");
    repeat (3) tick();
    chk(!fetch_req, "R5 no fetch while paused", 32'(fetch_req), 32'd0);
    go(1'b1, 16'h7770);
    serve_fetch(dsc_addr(16'h3400, 1), dsc_ptr(16'h3400, 1, 2), 1, 0, 0, "R7 resume address");
    serve_xfer(1, 0, 0, 0, "R7 transfer");
    expect_end(S_DONE, "R7 resumed chain done");

    // R10 held pause meets abort at a non-final boundary
    go(1'b1, dsc_addr(16'h4000, 0));
    serve_fetch(dsc_addr(16'h4000, 0), dsc_ptr(16'h4000, 0, 3), 1, 0, 0, "R10 fetch");
    serve_xfer(1, 0, 1, 1, "R10 transfer");
    expect_end(S_ABORTED, "R10 abort beats pause");

    // R8 abort together with final done gives done
    go(1'b1, dsc_addr(16'h4400, 0));
    serve_fetch(dsc_addr(16'h4400, 0), dsc_ptr(16'h4400, 0, 1), 1, 0, 0, "R8 fetch");
    serve_xfer(1, 0, 1, 0, "R8 transfer");
    expect_end(S_DONE, "R8 abort with last done");

    // R8 abort during fetch, then no resume possible
    go(1'b1, dsc_addr(16'h4800, 0));
    serve_fetch(dsc_addr(16'h4800, 0), 16'h0, 0, 0, 1, "R8 fetch aborted");
    expect_end(S_ABORTED, "R8 abort in fetch");
    chk(!fetch_req && !xfer_req, "R8 requests dropped", {30'd0, fetch_req, xfer_req}, 32'd0);
    go(1'b1, dsc_addr(16'h4C00, 0));
    serve_fetch(dsc_addr(16'h4C00, 0), dsc_ptr(16'h4C00, 0, 1), 1, 0, 0, "R8 fresh start after abort");
    serve_xfer(1, 0, 0, 0, "R8 transfer");
    expect_end(S_DONE, "R8 fresh run done");

    // R9 transfer error together with abort, then fresh start
    go(1'b1, dsc_addr(16'h5000, 0));
    serve_fetch(dsc_addr(16'h5000, 0), dsc_ptr(16'h5000, 0, 3), 1, 0, 0, "R9 fetch");
    serve_xfer(0, 1, 1, 0, "R9 transfer");
    expect_end(S_ERROR, "R9 error beats abort");
    go(1'b1, dsc_addr(16'h5400, 0));
    serve_fetch(dsc_addr(16'h5400, 0), 16'h0, 0, 1, 0, "R9 fresh start address");
    expect_end(S_ERROR, "R9 fetch error");

    // R11 start while busy ignored; pause while idle ignored
    go(1'b1, dsc_addr(16'h6000, 0));
    serve_fetch(dsc_addr(16'h6000, 0), dsc_ptr(16'h6000, 0, 2), 1, 0, 0, "R11 fetch");
    go(1'b1, 16'h7770);
    chk(xfer_req, "R11 busy start keeps transfer", 32'(xfer_req), 32'd1);
    serve_xfer(1, 0, 0, 0, "R11 transfer");
    serve_fetch(dsc_addr(16'h6000, 1), dsc_ptr(16'h6000, 1, 2), 1, 0, 0, "R11 chain unaffected");
    serve_xfer(1, 0, 0, 0, "R11 transfer");
    expect_end(S_DONE, "R11 done");
    pause_req = 1'b1; abort_req = 1'b1; tick(); pause_req = 1'b0; abort_req = 1'b0;
    go(1'b1, dsc_addr(16'h6400, 0));
    for (int i = 0; i < 2; i++) begin
      serve_fetch(dsc_addr(16'h6400, i), dsc_ptr(16'h6400, i, 2), 1, 0, 0, "R11 idle pause discarded");
      serve_xfer(1, 0, 0, 0, "R11 transfer");
    end
    expect_end(S_DONE, "R11 idle requests discarded");

    // Random chains mixing R3 R5 R7 R8 R9
    for (int it = 0; it < 60; it++) begin
      int n, base, act;
      bit mode, ended;
      logic [2:0] exp_st;
      n = 1 + int'($urandom % 4);
      mode = 1'($urandom % 2);
      base = 16'h8000 + it * 64;
      irq_en = 1'($urandom % 2);
      go(mode, dsc_addr(base, 0));
      if (!mode) begin
        act = int'($urandom % 4);
        serve_xfer(act != 2 && act != 1, act == 2, act == 1, act == 3, "R2 random direct");
        exp_st = (act == 1) ? S_ABORTED : (act == 2) ? S_ERROR : S_DONE;
        expect_end(exp_st, "R8 R9 random direct end");
      end else begin
        ended = 1'b0;
        for (int i = 0; i < n && !ended; i++) begin
          if ($urandom % 10 == 0) begin
            serve_fetch(dsc_addr(base, i), 16'h0, 0, 1, 0, "R3 random fetch");
            expect_end(S_ERROR, "R9 random fetch error");
            ended = 1'b1;
          end else begin
            serve_fetch(dsc_addr(base, i), dsc_ptr(base, i, n), 1, 0, 0, "R3 random fetch");
            act = int'($urandom % 6);
            serve_xfer(1, 0, act == 0, act == 1, "R3 random transfer");
            if (i == n - 1) begin
              expect_end(S_DONE, "R3 random chain done");
              ended = 1'b1;
            end else if (act == 0) begin
              expect_end(S_ABORTED, "R8 random abort");
              ended = 1'b1;
            end else if (act == 1) begin
              expect_end(S_PAUSED, "R5 random pause");
              chk(next_link == dsc_addr(base, i + 1), "R7 saved link", 32'(next_link), 32'(dsc_addr(base, i + 1)));
              go(1'b1, 16'h7770);
            end else begin
              chk(status == S_BUSY, "R3 random busy", 32'(status), 32'(S_BUSY));
            end
          end
        end
      end
      tick();
    end

    summary();
  end

endmodule